// File: doc/BRIEF.md
# Stereo Audio Serial Transmit Port

This block sits between a stereo converter core and a two-wire-plus-data audio serial link. The core hands over a left and a right 18-bit two's-complement word, captured at the same instant, with a one-cycle valid strobe. The port keeps that pair and shifts it out MSB first on a single data line. The left word goes out while the word clock is high and the right word while it is low. A new pair only ever starts at a left-slot boundary, so both halves of a word-clock period always come from the same sampling instant.

A strap read on the data pad during reset picks the clocking role. When the pad reads low (pulled down), the port is clock master. It divides its reference clock by 4 to make a bit clock and by 256 to make the word clock, and it drives both. When the pad reads high, the port is a clock slave. It takes the bit clock and word clock as inputs through synchronisers and follows them. In slave mode the reference clock must run at 256, 384 or 512 times the word-clock rate. The data and clock drivers stay off throughout reset, so the strap can be read undisturbed.

A small state machine sequences the port. Reset forces `HOLD`, and HOLD lasts one cycle after reset is released. From `HOLD` the transition *to master* leads to `MASTER` and the transition *to slave* leads to `SLAVE_ALIGN`. `SLAVE_ALIGN` takes the transition *aligned* to `SLAVE_RUN` on the first word-clock rising edge it sees. `MASTER` and `SLAVE_RUN` hold until the next reset.

Top module: `stereo_ser_tx`

## Requirements
- R1: The strap is sampled on every clock while `rst_n` is low: 0 selects master and 1 selects slave. The chosen mode is kept until the next reset, and later strap changes are ignored. During reset `ser_oe` and `clk_oe` are 0.
- R2: In master mode `bclk_o` has a period of 4 reference clocks, high for 2 and low for 2.
- R3: In master mode `wclk_o` has a period of 256 reference clocks and is high for the first 128 of them. It changes only on a falling edge of `bclk_o`.
- R4: A word-clock period holds 64 bit slots, sent in this order: 32 for the left word (word clock high), then 32 for the right word (word clock low). Each slot half carries its 18 data bits MSB first, followed by 14 zero bits.
- R5: `ser_out` changes only on a falling edge of the bit clock, so it is stable at each rising edge, where the receiver samples it.
- R6: A strobed pair becomes active only at the next left-slot boundary. A pair strobed in mid-frame leaves both halves of the current frame unchanged.
- R7: With no new strobe, the active pair is sent again in each frame. When several pairs are strobed before one boundary, the last one is sent.
- R8: In slave mode the port drives no clocks (`clk_oe`=0, `bclk_o`=0). The bit sampled on each rising edge of `bclk_i` follows the R4 frame, with the frame starting at a rising edge of `wclk_i`. This holds for reference-to-bit-clock ratios of 4 and 8, from the second frame after reset onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all logic runs on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_i | input | 1 | Level seen on the data pad; read as the mode strap during reset |
| smp_valid | input | 1 | One-cycle strobe: a new stereo pair is on `smp_left`/`smp_right` |
| smp_left | input | 18 | Left sample, two's complement |
| smp_right | input | 18 | Right sample, two's complement |
| bclk_i | input | 1 | External bit clock (slave mode) |
| wclk_i | input | 1 | External word clock (slave mode) |
| ser_out | output | 1 | Serial data |
| ser_oe | output | 1 | Output enable for the serial data pad |
| bclk_o | output | 1 | Generated bit clock (master mode) |
| wclk_o | output | 1 | Generated word clock (master mode) |
| clk_oe | output | 1 | Output enable for the bit and word clock pads |

## Verification
The frame is exercised with two kinds of pair. Alternating-bit words (0x2AAAA/0x15555) catch a swapped bit order or a shifted slot. Full-scale negative and positive words (0x20000/0x1FFFF) separate the MSB from the zero padding and show whether left and right are swapped. A pair strobed ten bit clocks into a frame shows whether loading is held to the boundary rather than applied at once, and two pairs strobed in one frame show that the latest one wins. The slave runs are repeated at bit-clock ratios of 4 and 8, which shows whether the position counter follows the external edges rather than a fixed division.

// File: rtl/stx_pkg.sv
package stx_pkg;

    // Sequencer states of the serial port.
    typedef enum logic [1:0] {
        ST_HOLD        = 2'd0,  // reset and first cycle after it: pads off
        ST_MASTER      = 2'd1,  // clocks generated locally
        ST_SLAVE_ALIGN = 2'd2,  // waiting for first external word-clock rise
        ST_SLAVE_RUN   = 2'd3   // following external clocks
    } port_state_e;

endpackage

// File: rtl/stx_clk_divider.sv
// Free-running frame counter for master mode; the low bits divide to the
// bit clock, the top bit gives the word clock.
module stx_clk_divider #(
    parameter int CNT_W   = 8,
    parameter int DIV_LOG = 2
) (
    input  logic                     ref_clk,
    input  logic                     rst_n,
    input  logic                     run_i,
    output logic [CNT_W-DIV_LOG-1:0] pos_o,
    output logic                     bclk_o,
    output logic                     wclk_o,
    output logic                     bit_end_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge ref_clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign pos_o     = cnt_q[CNT_W-1:DIV_LOG];
    assign bclk_o    = cnt_q[DIV_LOG-1];
    assign wclk_o    = ~cnt_q[CNT_W-1];
    assign bit_end_o = run_i && (&cnt_q[DIV_LOG-1:0]);

endmodule

// File: rtl/stx_edge_sync.sv
// Multi-stage synchroniser with edge detection for one external clock line.
module stx_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);

    logic [STAGES:0] chain_q;

    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-1:0], async_i};
        end
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] && !chain_q[STAGES];
    assign fall_o  = !chain_q[STAGES-1] && chain_q[STAGES];

endmodule

// File: rtl/stx_pair_store.sv
// Pending pair (written by the strobe) and active pair (swapped in only on
// a frame load request). next_* shows the pair active after this edge.
module stx_pair_store #(
    parameter int WORD_W = 18
) (
    input  logic              ref_clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic [WORD_W-1:0] cap_l_i,
    input  logic [WORD_W-1:0] cap_r_i,
    input  logic              load_i,
    output logic [WORD_W-1:0] next_l_o,
    output logic [WORD_W-1:0] next_r_o,
    output logic [WORD_W-1:0] act_l_o,
    output logic [WORD_W-1:0] act_r_o
);

    logic [WORD_W-1:0] pend_l_q, pend_r_q;
    logic [WORD_W-1:0] act_l_q, act_r_q;
    logic              pend_full_q;
    logic              take;

    assign take     = load_i && pend_full_q;
    assign next_l_o = take ? pend_l_q : act_l_q;
    assign next_r_o = take ? pend_r_q : act_r_q;
    assign act_l_o  = act_l_q;
    assign act_r_o  = act_r_q;

    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            pend_l_q    <= '0;
            pend_r_q    <= '0;
            act_l_q     <= '0;
            act_r_q     <= '0;
            pend_full_q <= 1'b0;
        end else begin
            if (take) begin
                act_l_q <= pend_l_q;
                act_r_q <= pend_r_q;
            end
            if (cap_i) begin
                pend_l_q    <= cap_l_i;
                pend_r_q    <= cap_r_i;
                pend_full_q <= 1'b1;
            end else if (take) begin
                pend_full_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/stx_slot_mux.sv
// Selects the bit for a frame position: top position bit picks the
// channel, the rest index a zero-padded, MSB-first slot.
module stx_slot_mux #(
    parameter int WORD_W = 18,
    parameter int SLOT_W = 32,
    parameter int POS_W  = 6
) (
    input  logic [POS_W-1:0]  pos_i,
    input  logic [WORD_W-1:0] left_i,
    input  logic [WORD_W-1:0] right_i,
    output logic              bit_o
);

    localparam int SLOT_LOG = $clog2(SLOT_W);
    localparam int PAD_W    = SLOT_W - WORD_W;

    logic [SLOT_LOG-1:0] idx;
    logic [WORD_W-1:0]   word;
    logic [SLOT_W-1:0]   slot_vec;

    assign idx      = pos_i[SLOT_LOG-1:0];
    assign word     = pos_i[SLOT_LOG] ? right_i : left_i;
    assign slot_vec = {word, {PAD_W{1'b0}}};
    assign bit_o    = slot_vec[~idx];

endmodule

// File: rtl/stereo_ser_tx.sv
module stereo_ser_tx #(
    parameter int WORD_W      = 18,
    parameter int SLOT_W      = 32,
    parameter int BCLK_DIV    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              ref_clk,
    input  logic              rst_n,
    input  logic              strap_i,
    input  logic              smp_valid,
    input  logic [WORD_W-1:0] smp_left,
    input  logic [WORD_W-1:0] smp_right,
    input  logic              bclk_i,
    input  logic              wclk_i,
    output logic              ser_out,
    output logic              ser_oe,
    output logic              bclk_o,
    output logic              wclk_o,
    output logic              clk_oe
);
    import stx_pkg::*;

    localparam int FRAME_BITS = 2 * SLOT_W;
    localparam int POS_W      = $clog2(FRAME_BITS);
    localparam int DIV_LOG    = $clog2(BCLK_DIV);
    localparam int CNT_W      = POS_W + DIV_LOG;
    localparam logic [POS_W-1:0] POS_LAST  = POS_W'(FRAME_BITS - 1);
    localparam logic [POS_W-1:0] POS_RIGHT = POS_W'(SLOT_W);

    port_state_e       state_q, state_d;
    logic              slave_q;
    logic [POS_W-1:0]  pos_q, launch_pos, div_pos;
    logic              launch, frame_load, mux_bit, ser_q;
    logic              div_bclk, div_wclk, div_bit_end, run_master;
    logic [1:0]        ext_raw, ext_lvl, ext_rise, ext_fall;
    logic              bk_rise, wc_rise, wc_fall;
    logic [WORD_W-1:0] next_l, next_r, act_l, act_r;

    // ---------------- mode strap (R1) ----------------
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            slave_q <= strap_i;
        end
    end

    // ---------------- master clock divider ----------------
    assign run_master = (state_q == ST_MASTER);

    stx_clk_divider #(.CNT_W(CNT_W), .DIV_LOG(DIV_LOG)) u_div (
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .run_i     (run_master),
        .pos_o     (div_pos),
        .bclk_o    (div_bclk),
        .wclk_o    (div_wclk),
        .bit_end_o (div_bit_end)
    );

    // ---------------- slave clock synchronisers ----------------
    assign ext_raw = {wclk_i, bclk_i};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        stx_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .ref_clk (ref_clk),
            .rst_n   (rst_n),
            .async_i (ext_raw[g]),
            .level_o (ext_lvl[g]),
            .rise_o  (ext_rise[g]),
            .fall_o  (ext_fall[g])
        );
    end

    assign bk_rise = ext_rise[0];
    assign wc_rise = ext_rise[1];
    assign wc_fall = ext_fall[1];

    // ---------------- sequencer: state register ----------------
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- sequencer: next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:        state_d = slave_q ? ST_SLAVE_ALIGN : ST_MASTER;
            ST_SLAVE_ALIGN: if (wc_rise) state_d = ST_SLAVE_RUN;
            ST_MASTER:      state_d = ST_MASTER;
            ST_SLAVE_RUN:   state_d = ST_SLAVE_RUN;
        endcase
    end

    // ---------------- bit launch decision ----------------
    // Master: launch at the reference edge where the bit clock falls.
    // Slave: launch the next position after each detected bit-clock rise;
    // word-clock edges re-anchor the position to a slot start.
    always_comb begin
        launch     = 1'b0;
        launch_pos = pos_q;
        unique case (state_q)
            ST_HOLD: begin
                launch = 1'b0;
            end
            ST_MASTER: begin
                if (div_bit_end) begin
                    launch     = 1'b1;
                    launch_pos = div_pos + 1'b1;
                end
            end
            ST_SLAVE_ALIGN: begin
                if (wc_rise) begin
                    launch     = 1'b1;
                    launch_pos = '0;
                end
            end
            ST_SLAVE_RUN: begin
                if (wc_rise) begin
                    launch     = 1'b1;
                    launch_pos = '0;
                end else if (wc_fall) begin
                    launch     = 1'b1;
                    launch_pos = POS_RIGHT;
                end else if (bk_rise) begin
                    launch     = 1'b1;
                    launch_pos = pos_q + 1'b1;
                end
            end
        endcase
    end

    // A pair is taken only when the position moves onto the left-slot start.
    assign frame_load = launch && (launch_pos == '0) && (pos_q != '0);

    stx_pair_store #(.WORD_W(WORD_W)) u_store (
        .ref_clk  (ref_clk),
        .rst_n    (rst_n),
        .cap_i    (smp_valid),
        .cap_l_i  (smp_left),
        .cap_r_i  (smp_right),
        .load_i   (frame_load),
        .next_l_o (next_l),
        .next_r_o (next_r),
        .act_l_o  (act_l),
        .act_r_o  (act_r)
    );

    stx_slot_mux #(.WORD_W(WORD_W), .SLOT_W(SLOT_W), .POS_W(POS_W)) u_mux (
        .pos_i   (launch_pos),
        .left_i  (next_l),
        .right_i (next_r),
        .bit_o   (mux_bit)
    );

    // ---------------- outputs process ----------------
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            pos_q <= POS_LAST;
            ser_q <= 1'b0;
        end else if (launch) begin
            pos_q <= launch_pos;
            ser_q <= mux_bit;
        end
    end

    assign ser_out = ser_q;
    assign ser_oe  = (state_q != ST_HOLD);
    assign clk_oe  = run_master;
    assign bclk_o  = run_master && div_bclk;
    assign wclk_o  = run_master && div_wclk;

endmodule

// File: rtl/stereo_ser_tx_chk.sv
module stereo_ser_tx_chk #(
    parameter int WORD_W = 18,
    parameter int SLOT_W = 32,
    parameter int POS_W  = 6
) (
    input logic              ref_clk,
    input logic              rst_n,
    input logic              ser_out,
    input logic              ser_oe,
    input logic              bclk_o,
    input logic              wclk_o,
    input logic              clk_oe,
    input logic [POS_W-1:0]  pos_q,
    input logic [WORD_W-1:0] act_l,
    input logic [WORD_W-1:0] act_r
);

    localparam int SLOT_LOG = $clog2(SLOT_W);

    logic was_rst_q = 1'b0;
    always_ff @(posedge ref_clk) was_rst_q <= !rst_n;

    // R1: pads released while in reset
    always_ff @(posedge ref_clk) begin
        if (was_rst_q) begin
            p_pads_off_in_reset_r1: assert (!ser_oe && !clk_oe)
                else $error("pads driven during reset");
        end
    end

    // R1: mode held once running
    p_mode_latched_r1: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (ser_oe && $past(ser_oe)) |-> (clk_oe == $past(clk_oe)));

    // R2: bit clock toggles every two reference cycles
    p_bclk_div_r2: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (clk_oe && $past(clk_oe) && $past(clk_oe, 2)) |-> (bclk_o != $past(bclk_o, 2)));

    // R3: word clock moves only with a falling bit clock
    p_wclk_on_fall_r3: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (clk_oe && $past(clk_oe) && (wclk_o != $past(wclk_o))) |-> $fell(bclk_o));

    // R5: data moves only with a falling bit clock
    p_data_on_fall_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (clk_oe && $past(clk_oe) && (ser_out != $past(ser_out))) |-> $fell(bclk_o));

    // R4: padding slots are driven low
    p_pad_low_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (ser_oe && (pos_q[SLOT_LOG-1:0] >= WORD_W)) |-> !ser_out);

    // R6: active pair changes only at the left-slot start
    p_load_at_boundary_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        ((act_l != $past(act_l)) || (act_r != $past(act_r)))
            |-> ((pos_q == '0) && ($past(pos_q) != '0)));

endmodule

bind stereo_ser_tx stereo_ser_tx_chk #(
    .WORD_W (WORD_W),
    .SLOT_W (SLOT_W),
    .POS_W  (POS_W)
) u_chk (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .ser_out (ser_out),
    .ser_oe  (ser_oe),
    .bclk_o  (bclk_o),
    .wclk_o  (wclk_o),
    .clk_oe  (clk_oe),
    .pos_q   (pos_q),
    .act_l   (act_l),
    .act_r   (act_r)
);

// File: tb/stereo_ser_tx_test.sv
`timescale 1ns/1ps
module stereo_ser_tx_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        ref_clk = 1'b0;
    logic        rst_n   = 1'b0;
    logic        strap_i = 1'b0;
    logic        smp_valid = 1'b0;
    logic [17:0] smp_left  = '0;
    logic [17:0] smp_right = '0;
    logic        bclk_i, wclk_i;
    logic        ser_out, ser_oe, bclk_o, wclk_o, clk_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // external clock model for slave mode, advanced on the falling reference edge
    logic       slv_en = 1'b0;
    int         slv_log = 2;
    logic [8:0] scnt = '0;

    always #(CLK_PERIOD/2) ref_clk = ~ref_clk;

    always @(negedge ref_clk) if (slv_en) scnt <= scnt + 1'b1;
    assign bclk_i = slv_en && scnt[slv_log-1];
    assign wclk_i = slv_en && !scnt[slv_log+5];

    stereo_ser_tx uut (
        .ref_clk(ref_clk), .rst_n(rst_n), .strap_i(strap_i),
        .smp_valid(smp_valid), .smp_left(smp_left), .smp_right(smp_right),
        .bclk_i(bclk_i), .wclk_i(wclk_i),
        .ser_out(ser_out), .ser_oe(ser_oe), .bclk_o(bclk_o),
        .wclk_o(wclk_o), .clk_oe(clk_oe)
    );

    function automatic logic [63:0] exp_frame(input logic [17:0] l, input logic [17:0] r);
        return {l, 14'b0, r, 14'b0};
    endfunction

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic do_reset(input logic strap, input int ratio_log);
        slv_en  = 1'b0;
        slv_log = ratio_log;
        scnt    = 9'(1 << (ratio_log + 5));
        rst_n   = 1'b0;
        strap_i = strap;
        repeat (4) @(negedge ref_clk);
        chk("R1 pads off in reset", {62'b0, ser_oe, clk_oe}, 64'd0);
        rst_n  = 1'b1;
        slv_en = strap;
        repeat (3) @(negedge ref_clk);
    endtask

    task automatic send_pair(input logic [17:0] l, input logic [17:0] r);
        @(negedge ref_clk);
        smp_valid = 1'b1; smp_left = l; smp_right = r;
        @(negedge ref_clk);
        smp_valid = 1'b0;
    endtask

    // frame bit 63 holds position 0
    task automatic grab_frame(input bit slave, output logic [63:0] f);
        if (slave) @(posedge wclk_i); else @(posedge wclk_o);
        for (int b = 0; b < 64; b++) begin
            if (slave) @(posedge bclk_i); else @(posedge bclk_o);
            #1 f[63-b] = ser_out;
        end
    endtask

    task automatic wait_bits(input bit slave, input int n);
        for (int k = 0; k < n; k++) begin
            if (slave) @(posedge bclk_i); else @(posedge bclk_o);
        end
    endtask

    task automatic t_master_mode;
        do_reset(1'b0, 2);
        chk("R1 master selected", {63'b0, clk_oe}, 64'd1);
        strap_i = 1'b1;
        repeat (5) @(negedge ref_clk);
        chk("R1 strap ignored after reset", {62'b0, clk_oe, ser_oe}, 64'd3);
    endtask

    task automatic t_master_clocks;
        realtime t0, t1, t2;
        @(posedge bclk_o); t0 = $realtime;
        @(negedge bclk_o); t1 = $realtime;
        @(posedge bclk_o); t2 = $realtime;
        chk("R2 bclk period", 64'(int'((t2 - t0) / CLK_PERIOD)), 64'd4);
        chk("R2 bclk high time", 64'(int'((t1 - t0) / CLK_PERIOD)), 64'd2);
        @(posedge wclk_o); t0 = $realtime;
        @(negedge wclk_o); t1 = $realtime;
        @(posedge wclk_o); t2 = $realtime;
        chk("R3 wclk period", 64'(int'((t2 - t0) / CLK_PERIOD)), 64'd256);
        chk("R3 wclk high time", 64'(int'((t1 - t0) / CLK_PERIOD)), 64'd128);
    endtask

    task automatic t_master_edges;
        int bad = 0;
        logic prev_d, prev_b;
        @(negedge ref_clk);
        prev_d = ser_out; prev_b = bclk_o;
        for (int k = 0; k < 600; k++) begin
            @(negedge ref_clk);
            if (ser_out != prev_d && !(prev_b && !bclk_o)) bad++;
            prev_d = ser_out; prev_b = bclk_o;
        end
        chk("R5 data moves only on bclk fall", 64'(bad), 64'd0);
    endtask

    task automatic t_master_frames;
        logic [63:0] f;
        send_pair(18'h2AAAA, 18'h15555);
        grab_frame(1'b0, f);
        chk("R4 alternating pair", f, exp_frame(18'h2AAAA, 18'h15555));
        send_pair(18'h20000, 18'h1FFFF);
        grab_frame(1'b0, f);
        chk("R4 full-scale pair", f, exp_frame(18'h20000, 18'h1FFFF));
    endtask

    task automatic t_hold(input bit slave, input logic [17:0] ol, input logic [17:0] orr,
                          input logic [17:0] nl, input logic [17:0] nr);
        logic [63:0] f;
        fork
            grab_frame(slave, f);
            begin
                if (slave) @(posedge wclk_i); else @(posedge wclk_o);
                wait_bits(slave, 10);
                send_pair(nl, nr);
            end
        join
        chk("R6 mid-frame pair not applied", f, exp_frame(ol, orr));
        grab_frame(slave, f);
        chk("R6 pair applied at next boundary", f, exp_frame(nl, nr));
    endtask

    task automatic t_repeat_and_latest;
        logic [63:0] f;
        grab_frame(1'b0, f);
        chk("R7 pair repeated without strobe", f, exp_frame(18'h0F0F0, 18'h30303));
        fork
            grab_frame(1'b0, f);
            begin
                @(posedge wclk_o);
                wait_bits(1'b0, 5);
                send_pair(18'h11111, 18'h22222);
                wait_bits(1'b0, 20);
                send_pair(18'h3C3C3, 18'h01234);
            end
        join
        grab_frame(1'b0, f);
        chk("R7 latest strobe wins", f, exp_frame(18'h3C3C3, 18'h01234));
    endtask

    task automatic t_slave(input int ratio_log, input logic [17:0] l, input logic [17:0] r);
        logic [63:0] f;
        do_reset(1'b1, ratio_log);
        chk("R8 slave drives no clocks", {61'b0, clk_oe, bclk_o, ser_oe}, 64'd1);
        send_pair(l, r);
        grab_frame(1'b1, f);
        grab_frame(1'b1, f);
        chk($sformatf("R8 slave frame ratio %0d", 1 << ratio_log), f, exp_frame(l, r));
    endtask

    initial begin
        t_master_mode();
        t_master_clocks();
        t_master_edges();
        t_master_frames();
        t_hold(1'b0, 18'h20000, 18'h1FFFF, 18'h0F0F0, 18'h30303);
        t_repeat_and_latest();
        t_slave(2, 18'h2AAAA, 18'h15555);
        t_hold(1'b1, 18'h2AAAA, 18'h15555, 18'h3FFFF, 18'h00001);
        t_slave(3, 18'h1FFFF, 18'h20000);
        t_hold(1'b1, 18'h1FFFF, 18'h20000, 18'h12345, 18'h2BCDE);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge ref_clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired got running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule